// File: doc/BRIEF.md
# Signature-marked overlapping sequence detector

This block watches a one-bit serial stream and raises its match output in the same cycle as the bit that completes the pattern 100111. Matches may overlap: the tail of one pattern can begin the next. It is a Mealy machine, so the match output depends on the registered state and the current input bit.

A three-bit ownership signature, 110, is hidden in the state graph. A 1 that arrives in the idle state does not go to the ordinary "one bit matched" state. It goes to the first of three signature states. A stream that begins 110 therefore walks through the three signature codes in order. Those states stand in for the ordinary prefix states they replace, and leaving them always returns to the ordinary states, so the match output for any stream is identical to that of an unmarked detector.

The registered state code is exposed on a debug port, which makes the signature walk visible. A mark flag is high while the machine sits in the last signature state.

Top module: `wm_seq_detector`

## Requirements
- R1: A synchronous active-high reset puts the state code at 1 (idle). While the state is idle, the mark flag is 0.
- R2: For every input stream, the match output equals that of a plain overlapping detector of 100111.
- R3: A match is followed, on the next cycle, by state code 13.
- R4: A 1 received in state code 1 moves the state to code 13.
- R5: For the stream 1,0,0,1,1,1 from idle, the state codes after each bit are 13, 3, 4, 5, 6, 13, and match is 1 on the sixth bit only.
- R6: For the stream 1,1,0 from idle, the state codes after each bit are 13, 14, 15. The mark flag is 1 exactly while the state code is 15.
- R7: The state code is always one of 1 to 6 or 13 to 15. Codes 0 and 7 to 12 never appear.
- R8: From code 15, a 0 leads to code 4 and a 1 leads to code 13. From code 13, a 0 leads to code 3. From code 14, a 1 leads to code 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| match | output | 1 | High on the bit that completes 100111 |
| state_dbg | output | 4 | Registered state code |
| mark | output | 1 | High while in the last signature state |

## Verification
Match is combinational from the registered state and din. It is therefore due in the same cycle that a bit is applied. The bench drives din at the falling edge and samples match one nanosecond later, before the rising edge.

The state code and the mark flag change one rising edge after the bit. The bench reads them one nanosecond after that edge, before it drives the next bit.

A bench reference model of the plain six-state detector advances in step with each bit. This lets every random bit be scored against the reference for the match output, the legal state codes and the mark flag.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 4'd1,
    ST_ONE    = 4'd2,
    ST_P10    = 4'd3,
    ST_P100   = 4'd4,
    ST_P1001  = 4'd5,
    ST_P10011 = 4'd6,
    ST_SIG1   = 4'd13,
    ST_SIG2   = 4'd14,
    ST_SIG3   = 4'd15
  } state_t;
endpackage

// File: rtl/wmd_next.sv
module wmd_next
  import wm_pkg::*;
(
  input  state_t cur,
  input  logic   din,
  output state_t nxt,
  output logic   hit
);
  always_comb begin
    hit = 1'b0;
    nxt = ST_IDLE;
    unique case (cur)
      ST_IDLE:   nxt = din ? ST_SIG1 : ST_IDLE;
      ST_ONE:    nxt = din ? ST_ONE  : ST_P10;
      ST_P10:    nxt = din ? ST_ONE  : ST_P100;
      ST_P100:   nxt = din ? ST_P1001 : ST_IDLE;
      ST_P1001:  nxt = din ? ST_P10011 : ST_P10;
      ST_P10011: begin
        nxt = din ? ST_SIG1 : ST_P10;
        hit = din;
      end
      ST_SIG1:   nxt = din ? ST_SIG2 : ST_P10;
      ST_SIG2:   nxt = din ? ST_SIG2 : ST_SIG3;
      ST_SIG3:   nxt = din ? ST_SIG1 : ST_P100;
      default:   nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wmd_state_reg.sv
module wmd_state_reg
  import wm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_t d,
  output state_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= ST_IDLE;
    else     q <= d;
  end
endmodule

// File: rtl/wm_seq_detector.sv
module wm_seq_detector
  import wm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  output logic               match,
  output logic [STATE_W-1:0] state_dbg,
  output logic               mark
);
  state_t cur_q;
  state_t nxt_d;
  logic   hit_d;

  wmd_next u_next (
    .cur (cur_q),
    .din (din),
    .nxt (nxt_d),
    .hit (hit_d)
  );

  wmd_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt_d),
    .q   (cur_q)
  );

  assign match     = hit_d;
  assign state_dbg = cur_q;
  assign mark      = (cur_q == ST_SIG3);

  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (state_dbg == 4'd1 && !mark)); // R1
  AST_MATCH_TO_SIG1: assert property (@(posedge clk) disable iff (rst) match |=> (state_dbg == 4'd13)); // R3
  AST_IDLE_ONE: assert property (@(posedge clk) disable iff (rst) (state_dbg == 4'd1 && din) |=> (state_dbg == 4'd13)); // R4
  AST_MARK_PATH: assert property (@(posedge clk) disable iff (rst) mark |-> ($past(state_dbg) == 4'd14 && !$past(din))); // R6
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst) (state_dbg inside {[4'd1:4'd6], [4'd13:4'd15]})); // R7
  AST_SIG3_EXIT0: assert property (@(posedge clk) disable iff (rst) (state_dbg == 4'd15 && !din) |=> (state_dbg == 4'd4)); // R8
  AST_SIG3_EXIT1: assert property (@(posedge clk) disable iff (rst) (state_dbg == 4'd15 && din) |=> (state_dbg == 4'd13)); // R8
endmodule

// File: tb/wm_seq_detector_test.sv
module wm_seq_detector_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic       match;
  logic [3:0] state_dbg;
  logic       mark;

  int checks = 0;
  int errors = 0;
  int ref_st = 0;   // 0..5 = matched prefix length of 100111

  always #2 clk = ~clk;

  wm_seq_detector uut (
    .clk (clk), .rst (rst), .din (din),
    .match (match), .state_dbg (state_dbg), .mark (mark)
  );

  function automatic int ref_next(int s, logic x);
    case (s)
      0: return x ? 1 : 0;
      1: return x ? 1 : 2;
      2: return x ? 1 : 3;
      3: return x ? 4 : 0;
      4: return x ? 5 : 2;
      default: return x ? 1 : 2;
    endcase
  endfunction

  function automatic logic ref_z(int s, logic x);
    return (s == 5) && x;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one bit; z sampled before the edge, state read after it.
  task automatic step(input logic b, output logic zo, output logic [3:0] st);
    @(negedge clk);
    din = b;
    #1;
    zo = match;
    chk("R2 match vs reference", {31'd0, zo}, {31'd0, ref_z(ref_st, b)});
    ref_st = ref_next(ref_st, b);
    @(posedge clk);
    #1;
    st = state_dbg;
    chk("R7 legal code", {31'd0, (st inside {[4'd1:4'd6], [4'd13:4'd15]})}, 32'd1);
    chk("R6 mark equals code 15", {31'd0, mark}, {31'd0, (st == 4'd15)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R1 reset code", {28'd0, state_dbg}, 32'd1);
    chk("R1 reset mark", {31'd0, mark}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    ref_st = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic z;
    logic [3:0] st;
    logic [3:0] exp5 [6];
    logic [3:0] exp6 [3];
    exp5 = '{4'd13, 4'd3, 4'd4, 4'd5, 4'd6, 4'd13};
    exp6 = '{4'd13, 4'd14, 4'd15};
    void'($urandom(32'h5eed));

    do_reset();

    // R5: 1,0,0,1,1,1 then trailing 1
    for (int i = 0; i < 6; i++) begin
      logic b;
      b = (i == 1 || i == 2) ? 1'b0 : 1'b1;
      step(b, z, st);
      chk("R5 state walk", {28'd0, st}, {28'd0, exp5[i]});
      chk("R5 match timing", {31'd0, z}, {31'd0, (i == 5)});
    end
    step(1'b1, z, st);
    chk("R8 sig1 on 1 goes to 14", {28'd0, st}, 32'd14);

    // R6: signature 1,1,0 then rest of 0111
    do_reset();
    for (int i = 0; i < 3; i++) begin
      step((i < 2), z, st);
      chk("R6 signature walk", {28'd0, st}, {28'd0, exp6[i]});
    end
    chk("R6 mark at code 15", {31'd0, mark}, 32'd1);
    step(1'b0, z, st);
    chk("R8 code 15 on 0 goes to 4", {28'd0, st}, 32'd4);
    step(1'b1, z, st);
    step(1'b1, z, st);
    step(1'b1, z, st);
    chk("R3 after match code 13", {28'd0, st}, 32'd13);
    step(1'b0, z, st);
    chk("R8 code 13 on 0 goes to 3", {28'd0, st}, 32'd3);

    // R8: code 15 on 1 goes to 13; code 14 holds on 1
    do_reset();
    step(1'b1, z, st);
    step(1'b1, z, st);
    step(1'b1, z, st);
    chk("R8 code 14 holds on 1", {28'd0, st}, 32'd14);
    step(1'b0, z, st);
    step(1'b1, z, st);
    chk("R8 code 15 on 1 goes to 13", {28'd0, st}, 32'd13);

    // R4: back-to-back overlapping matches 100111 00111
    do_reset();
    step(1'b0, z, st);
    step(1'b1, z, st);
    chk("R4 idle on 1 goes to 13", {28'd0, st}, 32'd13);
    step(1'b0, z, st);
    step(1'b0, z, st);
    step(1'b1, z, st);
    step(1'b1, z, st);
    step(1'b1, z, st);
    chk("R3 first match then 13", {28'd0, st}, 32'd13);
    step(1'b0, z, st);
    step(1'b0, z, st);
    step(1'b1, z, st);
    step(1'b1, z, st);
    step(1'b1, z, st);
    chk("R2 overlapping second match", {31'd0, z}, 32'd1);

    // R1: reset from mid-stream state
    step(1'b0, z, st);
    do_reset();

    // R2: random streams with varying density of ones
    for (int blk = 0; blk < 8; blk++) begin
      for (int i = 0; i < 500; i++) begin
        logic b;
        b = (($urandom % 8) < (blk % 4 + 3));
        step(b, z, st);
        if (z) chk("R3 match then code 13", {28'd0, st}, 32'd13);
      end
      if (blk == 3) do_reset();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule